// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Held Status Flags

This block is the arithmetic core of a small processor. It takes two operands and a 4-bit operation code and computes a result in the same cycle. It also computes four status flags: zero, carry, negative and signed overflow. The result and these "live" flags are purely combinational. Next to them sits a clocked flag register. That register copies the live flags only on a clock edge where the flag-write input is high. The sequencer raises flag-write for ALU-class instructions. It keeps flag-write low for loads, stores and branches, so a compare result stays intact until the branch that consumes it.

Subtraction does not have an adder of its own. It goes through the same adder as addition, with the second operand inverted and a carry-in of one. A pass-through operation lets operand B reach the result unchanged for moves and loads. Only single-bit shifts are provided.

Top module: `alu_status_unit`

## Requirements
- R1: Code 0 (add) gives result = (A + B) mod 2^WIDTH. Carry is the unsigned carry-out. Overflow is set when A and B have the same sign and the result's sign differs from it.
- R2: Code 1 (subtract) gives result = (A - B) mod 2^WIDTH, formed as A + ~B + 1. Carry is 1 exactly when A >= B as unsigned numbers, meaning no borrow occurred. Overflow is set when the signed difference falls outside the signed range.
- R3: Codes 2, 3, 4 and 5 give A AND B, A OR B, A XOR B and NOT A. Carry and overflow are 0 for all four.
- R4: Code 6 gives A shifted left by one with a 0 shifted in, and carry takes the old MSB of A. Code 7 gives A shifted right by one with a 0 shifted in, and carry takes the old LSB of A. Overflow is 0 for both.
- R5: Code 8 passes B to the result with carry and overflow at 0. Codes 9 to 15 give a zero result with carry and overflow at 0, so the zero flag is set.
- R6: The live flag vector puts zero at bit 0, carry at bit 1, negative at bit 2 and overflow at bit 3. Zero is set when every result bit is 0. Negative equals the result MSB.
- R7: On a rising edge with flag-write high and reset low, the held flags take the live flags present at that edge.
- R8: On a rising edge with flag-write low and reset low, the held flags keep their value, whatever the operation and operands.
- R9: A synchronous active-high reset clears the held flags to 0 and takes priority over flag-write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opSel | input | 4 | Operation code |
| flagWrEn | input | 1 | Capture live flags at the next edge |
| result | output | WIDTH | Combinational result |
| liveFlags | output | 4 | Combinational flags {V,N,C,Z} |
| heldFlags | output | 4 | Registered flags {V,N,C,Z} |

## Verification
Two things can happen on the same clock edge: reset, and a flag capture requested by flag-write. The bench provokes this by driving an operation with nonzero live flags while both reset and flag-write are high. It judges the outcome by held flags reading all zeros after the edge. It also pairs a capture with a later edge where flag-write is low and the operation has changed. After that edge the live flags must differ from the held ones, and the held flags must still equal the earlier capture.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_NOTA = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_PASS = 4'd8
  } aluOp_e;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_ADDER,
    SRC_LOGIC,
    SRC_SHIFT,
    SRC_PASS
  } resSrc_e;

  typedef enum logic [1:0] {
    LF_AND,
    LF_OR,
    LF_XOR,
    LF_NOT
  } logicFn_e;

  // strobes from decode to datapath
  typedef struct packed {
    resSrc_e  src;
    logic     invertB;
    logicFn_e logicFn;
    logic     shiftLeft;
  } aluCtrl_t;

  // bit 3..0 = overflow, negative, carry, zero
  typedef struct packed {
    logic overflow;
    logic negative;
    logic carry;
    logic zero;
  } aluFlags_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_status_pkg::*;
(
  input  logic [3:0] opSel,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl.src       = SRC_ZERO;
    ctrl.invertB   = 1'b0;
    ctrl.logicFn   = LF_AND;
    ctrl.shiftLeft = 1'b0;
    case (opSel)
      OP_ADD:  ctrl.src = SRC_ADDER;
      OP_SUB:  begin ctrl.src = SRC_ADDER; ctrl.invertB = 1'b1; end
      OP_AND:  begin ctrl.src = SRC_LOGIC; ctrl.logicFn = LF_AND; end
      OP_OR:   begin ctrl.src = SRC_LOGIC; ctrl.logicFn = LF_OR;  end
      OP_XOR:  begin ctrl.src = SRC_LOGIC; ctrl.logicFn = LF_XOR; end
      OP_NOTA: begin ctrl.src = SRC_LOGIC; ctrl.logicFn = LF_NOT; end
      OP_SHL:  begin ctrl.src = SRC_SHIFT; ctrl.shiftLeft = 1'b1; end
      OP_SHR:  ctrl.src = SRC_SHIFT;
      OP_PASS: ctrl.src = SRC_PASS;
      default: ctrl.src = SRC_ZERO;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_status_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output aluFlags_t        flags
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addB;
  logic [WIDTH:0]   sum;
  logic             carryOut;
  logic             ovfOut;

  // shared adder: subtract = A + ~B + 1
  assign addB = ctrl.invertB ? ~opB : opB;
  assign sum  = {1'b0, opA} + {1'b0, addB} + {{WIDTH{1'b0}}, ctrl.invertB};

  always_comb begin
    result   = '0;
    carryOut = 1'b0;
    ovfOut   = 1'b0;
    case (ctrl.src)
      SRC_ADDER: begin
        result   = sum[MSB:0];
        carryOut = sum[WIDTH];
        ovfOut   = (opA[MSB] == addB[MSB]) && (sum[MSB] != opA[MSB]);
      end
      SRC_LOGIC: begin
        case (ctrl.logicFn)
          LF_AND:  result = opA & opB;
          LF_OR:   result = opA | opB;
          LF_XOR:  result = opA ^ opB;
          default: result = ~opA;
        endcase
      end
      SRC_SHIFT: begin
        if (ctrl.shiftLeft) {carryOut, result} = {opA, 1'b0};
        else                {result, carryOut} = {1'b0, opA};
      end
      SRC_PASS: result = opB;
      default:  result = '0;
    endcase
  end

  assign flags.zero     = (result == '0);
  assign flags.negative = result[MSB];
  assign flags.carry    = carryOut;
  assign flags.overflow = ovfOut;

endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import alu_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      flagWrEn,
  input  aluFlags_t liveFlags,
  output aluFlags_t heldFlags
);

  always_ff @(posedge clk) begin
    if (rst)           heldFlags <= '0;
    else if (flagWrEn) heldFlags <= liveFlags;
  end

  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    flagWrEn |=> heldFlags == $past(liveFlags))
    else $error("R7 capture mismatch");

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !flagWrEn |=> heldFlags == $past(heldFlags))
    else $error("R8 held flags changed");

  p_reset_r9: assert property (@(posedge clk)
    rst |=> heldFlags == '0)
    else $error("R9 reset did not clear");

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_status_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opSel,
  input  logic             flagWrEn,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       liveFlags,
  output logic [3:0]       heldFlags
);

  aluCtrl_t  ctrl;
  aluFlags_t liveF;
  aluFlags_t heldF;

  alu_op_decode i_decode (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) i_datapath (
    .opA    (opA),
    .opB    (opB),
    .ctrl   (ctrl),
    .result (result),
    .flags  (liveF)
  );

  status_flag_reg i_flags (
    .clk       (clk),
    .rst       (rst),
    .flagWrEn  (flagWrEn),
    .liveFlags (liveF),
    .heldFlags (heldF)
  );

  assign liveFlags = liveF;
  assign heldFlags = heldF;

  p_add_sum_r1: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_ADD) |-> {liveF.carry, result} == ({1'b0, opA} + {1'b0, opB}))
    else $error("R1 add mismatch");

  p_sub_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_SUB) |-> liveF.carry == (opA >= opB))
    else $error("R2 borrow sense wrong");

  p_logic_flags_r3: assert property (@(posedge clk) disable iff (rst)
    (opSel >= OP_AND && opSel <= OP_NOTA) |-> !liveF.carry && !liveF.overflow)
    else $error("R3 logic op set C or V");

endmodule

// File: tb/test_alu_status_unit.sv
module test_alu_status_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [3:0] opSel = '0;
  logic       flagWrEn = 1'b0;
  logic [7:0] result;
  logic [3:0] liveFlags;
  logic [3:0] heldFlags;

  int checks = 0;
  int bad = 0;

  always #4 clk = ~clk;

  alu_status_unit #(.WIDTH(8)) i_alu_status_unit (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opSel(opSel),
    .flagWrEn(flagWrEn), .result(result), .liveFlags(liveFlags),
    .heldFlags(heldFlags)
  );

  // reference: returns {V,N,C,Z,result}
  function automatic logic [11:0] refAlu(logic [3:0] op, logic [7:0] a, logic [7:0] b);
    int sa; int sb; int r;
    logic [7:0] res; logic c; logic v;
    sa = int'($signed(a)); sb = int'($signed(b));
    c = 1'b0; v = 1'b0; res = '0;
    case (op)
      4'd0: begin r = int'(a) + int'(b); res = r[7:0]; c = (r > 255);
              v = (sa + sb > 127) || (sa + sb < -128); end
      4'd1: begin res = a - b; c = (a >= b);
              v = (sa - sb > 127) || (sa - sb < -128); end
      4'd2: res = a & b;
      4'd3: res = a | b;
      4'd4: res = a ^ b;
      4'd5: res = ~a;
      4'd6: begin res = {a[6:0], 1'b0}; c = a[7]; end
      4'd7: begin res = {1'b0, a[7:1]}; c = a[0]; end
      4'd8: res = b;
      default: res = '0;
    endcase
    return {v, res[7], c, (res == 8'd0), res};
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample comb outputs 1 ns later
  task automatic combCase(string req, logic [3:0] op, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    opSel = op; opA = a; opB = b;
    #1;
    check(req, {liveFlags, result}, refAlu(op, a, b));
  endtask

  task automatic t_reset();
    rst = 1'b1; flagWrEn = 1'b1; opSel = 4'd1; opA = 8'h00; opB = 8'h01;
    @(posedge clk); @(negedge clk);
    check("R9 reset state", {8'h00, heldFlags}, 12'h000);
    rst = 1'b0; flagWrEn = 1'b0;
  endtask

  task automatic t_add();
    combCase("R1 R6 add 7f+01", 4'd0, 8'h7F, 8'h01);
    combCase("R1 R6 add ff+01", 4'd0, 8'hFF, 8'h01);
    combCase("R1 add 12+34", 4'd0, 8'h12, 8'h34);
    combCase("R1 add 80+80", 4'd0, 8'h80, 8'h80);
  endtask

  task automatic t_sub();
    combCase("R2 sub 5-3", 4'd1, 8'h05, 8'h03);
    combCase("R2 sub 3-5", 4'd1, 8'h03, 8'h05);
    combCase("R2 sub 80-01", 4'd1, 8'h80, 8'h01);
    combCase("R2 R6 sub 7-7", 4'd1, 8'h07, 8'h07);
    combCase("R2 sub 7f-ff", 4'd1, 8'h7F, 8'hFF);
  endtask

  task automatic t_logic();
    combCase("R3 and", 4'd2, 8'hF0, 8'h3C);
    combCase("R3 or", 4'd3, 8'h81, 8'h02);
    combCase("R3 xor", 4'd4, 8'hAA, 8'hAA);
    combCase("R3 not", 4'd5, 8'h0F, 8'h00);
  endtask

  task automatic t_shift();
    combCase("R4 shl 81", 4'd6, 8'h81, 8'h00);
    combCase("R4 shr 81", 4'd7, 8'h81, 8'h00);
    combCase("R4 shr 01", 4'd7, 8'h01, 8'hFF);
  endtask

  task automatic t_pass_unused();
    combCase("R5 pass b", 4'd8, 8'h11, 8'h90);
    for (int k = 9; k < 16; k++)
      combCase("R5 unused code", 4'(k), 8'hFF, 8'hFF);
  endtask

  task automatic t_capture_hold();
    logic [11:0] first;
    logic [11:0] second;
    first = refAlu(4'd0, 8'h7F, 8'h01);   // V,N set
    @(negedge clk);
    opSel = 4'd0; opA = 8'h7F; opB = 8'h01; flagWrEn = 1'b1;
    @(posedge clk); #1;
    check("R7 capture", {8'h00, heldFlags}, {8'h00, first[11:8]});
    @(negedge clk);
    opSel = 4'd1; opA = 8'h04; opB = 8'h04; flagWrEn = 1'b0;   // Z,C live
    second = refAlu(4'd1, 8'h04, 8'h04);
    @(posedge clk); #1;
    check("R8 hold after edge", {8'h00, heldFlags}, {8'h00, first[11:8]});
    check("R8 live differs", {8'h00, liveFlags}, {8'h00, second[11:8]});
    @(posedge clk); #1;
    check("R8 hold second edge", {8'h00, heldFlags}, {8'h00, first[11:8]});
    @(negedge clk);
    flagWrEn = 1'b1;
    @(posedge clk); #1;
    check("R7 capture again", {8'h00, heldFlags}, {8'h00, second[11:8]});
  endtask

  task automatic t_reset_vs_write();
    @(negedge clk);
    opSel = 4'd0; opA = 8'hFF; opB = 8'hFF; flagWrEn = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    check("R9 reset beats write", {8'h00, heldFlags}, 12'h000);
    @(negedge clk);
    rst = 1'b0; flagWrEn = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_pass_unused();
    t_capture_hold();
    t_reset_vs_write();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule